// File: doc/BRIEF.md
# Two-Wire Target Serial Shift Unit

This block is the bit-level engine for the target side of a two-wire, open-drain serial bus. It samples the bus clock and data lines through synchronizers on the system clock. It detects start and stop conditions, shifts data in and out through an 8-bit register, and counts every clock-line edge with a 4-bit counter. It also stretches the bus clock by pulling it low. A separate controller makes all protocol decisions. That controller loads the counter and the data register, picks the stretch mode, drives the data line when sending, and clears flags. The unit itself makes no address or buffering decisions.

Because the counter steps on both edges of the bus clock, a count that starts at 0 covers a full byte in 16 edges. A preload of 14 covers exactly one bit, which is the usual way to send or sample an acknowledge. Clock stretching starts after a start condition. In the hold mode it also starts after a counter overflow. The system clock must run at least four times faster than the bus clock.

Top module: `twi_shift_unit`

## Requirements
- R1: After reset all four flags are 0, neither pull-low output is asserted, the edge counter is 0 and the data register is 0.
- R2: A falling data line while the clock line is high sets the start flag (flag bit 0).
- R3: While the start flag is set and the clock line is low, the clock pull-low output is asserted. It stays asserted until the start flag is cleared.
- R4: The edge counter increments once on every rising and every falling clock-line edge. When an edge arrives with the counter at 15, the counter wraps to 0 and the overflow flag (flag bit 1) is set.
- R5: On each rising clock-line edge the data register shifts left by one and takes the sampled data line into bit 0, so the first bit received ends in bit 7.
- R6: With the counter preloaded to 14, the overflow flag is set after exactly two clock-line edges.
- R7: With hold mode on (mode_hold=1), an overflow also holds the clock line low until the overflow flag is cleared. With hold mode off, an overflow never asserts the clock pull-low.
- R8: With drive_en=1, the data pull-low output is asserted exactly when the current output bit is 0. The output bit takes bit 7 of loaded data at load time, then takes bit 7 of the register after each falling clock-line edge, so bytes go out MSB first.
- R9: A rising data line while the clock line is high sets the stop flag (flag bit 2). It does not assert the clock pull-low.
- R10: A cycle with clr_valid=1 clears each flag whose clr_mask bit is 1 (bit 0 start, bit 1 overflow, bit 2 stop, bit 3 collision). Flags whose mask bit is 0 are left unchanged.
- R11: With drive_en=1 and the output bit at 1, a rising clock-line edge that samples the data line low sets the collision flag (flag bit 3).
- R12: A counter or data load takes effect in the next cycle and wins over a bus edge in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Sampled bus clock line |
| sda_in | input | 1 | Sampled bus data line |
| scl_pull_low | output | 1 | Pull bus clock line low (stretch) |
| sda_pull_low | output | 1 | Pull bus data line low |
| mode_hold | input | 1 | 1: an overflow also stretches the clock |
| drive_en | input | 1 | 1: the output bit drives the data line |
| ld_data_valid | input | 1 | Load the data register |
| ld_data | input | 8 | Data register load value |
| ld_cnt_valid | input | 1 | Load the edge counter |
| ld_cnt | input | 4 | Edge counter load value |
| clr_valid | input | 1 | Apply the write-1-to-clear mask |
| clr_mask | input | 4 | Flags to clear: start, overflow, stop, collision |
| shift_data | output | 8 | Data register contents |
| edge_cnt | output | 4 | Edge counter value |
| start_flag | output | 1 | Start condition seen |
| ovf_flag | output | 1 | Counter overflow seen |
| stop_flag | output | 1 | Stop condition seen |
| coll_flag | output | 1 | Data collision seen |

## Verification
The bench covers the following corner cases, each tied to the wrong behaviour it would expose:
- **Counting both clock edges.** A counter that counted only rising edges would show 1 instead of 2 after the first bit and would never overflow on the byte boundary.
- **The one-bit acknowledge preload of 14.** An off-by-one in the wrap would need three or four edges before the overflow flag rose.
- **The two stretch sources.** Hold mode must stall the bus after a byte. Plain mode must let the bus run, and a stop must never stretch. A wrong stretch rule would either deadlock the bus or let the master run past an unserviced byte.
- **Selective flag clearing.** Clearing overflow while a repeated start is pending must keep the start flag. A mask decoded one bit off would lose the start flag and release the clock early.
- **Collision detection.** Driving 1 while the master pulls the data line low must raise the collision flag.

// File: rtl/twsu_pkg.sv
// Package: shared constants for the two-wire serial shift unit.
// Assumes: flag bit positions are fixed because the controller's clear mask
// addresses flags by these indices.
package twsu_pkg;
    localparam int FLAG_N    = 4;
    localparam int FLG_START = 0;
    localparam int FLG_OVF   = 1;
    localparam int FLG_STOP  = 2;
    localparam int FLG_COLL  = 3;

    typedef logic [FLAG_N-1:0] flag_vec_t;
endpackage

// File: rtl/twsu_sync.sv
// Module: twsu_sync
// Multi-stage synchronizer for one asynchronous bus line.
// Assumes: the line idles high, so every stage resets to 1.
module twsu_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // first stage captures the raw line
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= din;
                end
            end else begin : g_next
                // later stages settle metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/twsu_line_mon.sv
// Module: twsu_line_mon
// Synchronizes both bus lines and derives clock edges and start/stop events.
// Assumes: the system clock is at least four times the bus clock, so each
// edge is seen as a single-cycle change of the synchronized level.
module twsu_line_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_d, sda_d;

    twsu_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .din(scl_in), .dout(scl_s)
    );
    twsu_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .din(sda_in), .dout(sda_d_unused_guard)
    );

    logic sda_d_unused_guard;
    assign sda_s = sda_d_unused_guard;

    // previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twsu_shifter.sv
// Module: twsu_shifter
// Data shift register, both-edge counter and output bit latch.
// Assumes: loads from the controller win over bus edges in the same cycle.
module twsu_shifter #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              ld_data_valid,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              ld_cnt_valid,
    input  logic [CNT_W-1:0]  ld_cnt,
    output logic [DATA_W-1:0] data_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              out_bit,
    output logic              wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic scl_edge;
    assign scl_edge = scl_rise | scl_fall;
    assign wrap     = scl_edge & ~ld_cnt_valid & (cnt_q == CNT_MAX);

    // data register: load or shift in on rising clock edge
    always_ff @(posedge clk) begin
        if (!rst_n)             data_q <= '0;
        else if (ld_data_valid) data_q <= ld_data;
        else if (scl_rise)      data_q <= {data_q[DATA_W-2:0], sda_s};
    end

    // edge counter: load or step on every clock edge
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (ld_cnt_valid) cnt_q <= ld_cnt;
        else if (scl_edge)     cnt_q <= cnt_q + 1'b1;
    end

    // output bit: presented after each falling edge, or on a data load
    always_ff @(posedge clk) begin
        if (!rst_n)             out_bit <= 1'b1;
        else if (ld_data_valid) out_bit <= ld_data[DATA_W-1];
        else if (scl_fall)      out_bit <= data_q[DATA_W-1];
    end
endmodule

// File: rtl/twsu_flags.sv
// Module: twsu_flags
// Sticky event flags with write-1-to-clear; a set wins over a clear.
// Assumes: set and clear vectors use the indices from twsu_pkg.
module twsu_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         clr_valid,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flag_q
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_flag
            // one sticky flag
            always_ff @(posedge clk) begin
                if (!rst_n)          flag_q[i] <= 1'b0;
                else if (set_vec[i]) flag_q[i] <= 1'b1;
                else if (clr_valid && clr_mask[i]) flag_q[i] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/twi_shift_unit.sv
// Module: twi_shift_unit (top)
// Target-side two-wire serial shift unit: line monitor, shifter, flags and
// clock-stretch control.
// Assumes: open-drain lines; a pull-low output of 1 drives the line low.
module twi_shift_unit #(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull_low,
    output logic              sda_pull_low,
    input  logic              mode_hold,
    input  logic              drive_en,
    input  logic              ld_data_valid,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              ld_cnt_valid,
    input  logic [CNT_W-1:0]  ld_cnt,
    input  logic              clr_valid,
    input  logic [3:0]        clr_mask,
    output logic [DATA_W-1:0] shift_data,
    output logic [CNT_W-1:0]  edge_cnt,
    output logic              start_flag,
    output logic              ovf_flag,
    output logic              stop_flag,
    output logic              coll_flag
);
    import twsu_pkg::*;

    logic      scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic      out_bit, wrap, coll_det, hold_req, stretch_q;
    flag_vec_t set_vec, flags;

    twsu_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    twsu_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_s(sda_s), .ld_data_valid(ld_data_valid), .ld_data(ld_data),
        .ld_cnt_valid(ld_cnt_valid), .ld_cnt(ld_cnt), .data_q(shift_data),
        .cnt_q(edge_cnt), .out_bit(out_bit), .wrap(wrap)
    );

    // collision: driving 1 but the bus reads 0 at the sampling edge
    assign coll_det = drive_en & out_bit & scl_rise & ~sda_s;

    // gather flag set events in package bit order
    always_comb begin
        set_vec            = '0;
        set_vec[FLG_START] = start_det;
        set_vec[FLG_OVF]   = wrap;
        set_vec[FLG_STOP]  = stop_det;
        set_vec[FLG_COLL]  = coll_det;
    end

    twsu_flags #(.N(FLAG_N)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_valid(clr_valid),
        .clr_mask(clr_mask), .flag_q(flags)
    );

    assign hold_req = flags[FLG_START] | (mode_hold & flags[FLG_OVF]);

    // stretch: grab the clock once it is low, hold while a source remains
    always_ff @(posedge clk) begin
        if (!rst_n) stretch_q <= 1'b0;
        else        stretch_q <= hold_req & (stretch_q | ~scl_s);
    end

    assign scl_pull_low = stretch_q;
    assign sda_pull_low = drive_en & ~out_bit;
    assign start_flag   = flags[FLG_START];
    assign ovf_flag     = flags[FLG_OVF];
    assign stop_flag    = flags[FLG_STOP];
    assign coll_flag    = flags[FLG_COLL];
endmodule

// File: rtl/twsu_checker.sv
// Module: twsu_checker
// Temporal checks on the shift unit's ports, bound to twi_shift_unit.
module twsu_checker #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_hold,
    input logic              drive_en,
    input logic              ld_data_valid,
    input logic              ld_cnt_valid,
    input logic              scl_pull_low,
    input logic [DATA_W-1:0] shift_data,
    input logic [CNT_W-1:0]  edge_cnt,
    input logic              start_flag,
    input logic              ovf_flag,
    input logic              coll_flag
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    // R3 R7
    stretch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_pull_low |-> $past(start_flag || (mode_hold && ovf_flag)));

    // R4
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(edge_cnt) == CNT_TOP) && (edge_cnt == '0));

    // R4 R12
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_cnt != $past(edge_cnt)) && !$past(ld_cnt_valid))
            |-> (edge_cnt == CNT_W'($past(edge_cnt) + 1'b1)));

    // R5 R12
    shift_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((shift_data != $past(shift_data)) && !$past(ld_data_valid))
            |-> (shift_data[DATA_W-1:1] == $past(shift_data[DATA_W-2:0])));

    // R11
    coll_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coll_flag) |-> $past(drive_en));
endmodule

bind twi_shift_unit twsu_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_hold(mode_hold), .drive_en(drive_en),
    .ld_data_valid(ld_data_valid), .ld_cnt_valid(ld_cnt_valid),
    .scl_pull_low(scl_pull_low), .shift_data(shift_data), .edge_cnt(edge_cnt),
    .start_flag(start_flag), .ovf_flag(ovf_flag), .coll_flag(coll_flag)
);

// File: tb/twi_shift_unit_tb.sv
// Directed bench: the bench plays both the bus master and the controller.
module twi_shift_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_line, sda_line, scl_pull_low, sda_pull_low;
    logic mode_hold = 1'b0, drive_en = 1'b0;
    logic ld_data_valid = 1'b0, ld_cnt_valid = 1'b0, clr_valid = 1'b0;
    logic [7:0] ld_data = '0;
    logic [3:0] ld_cnt = '0, clr_mask = '0;
    logic [7:0] shift_data;
    logic [3:0] edge_cnt;
    logic start_flag, ovf_flag, stop_flag, coll_flag;
    logic pull_mid;
    int   n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_line = scl_m & ~scl_pull_low;
    assign sda_line = sda_m & ~sda_pull_low;

    twi_shift_unit u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low),
        .mode_hold(mode_hold), .drive_en(drive_en),
        .ld_data_valid(ld_data_valid), .ld_data(ld_data),
        .ld_cnt_valid(ld_cnt_valid), .ld_cnt(ld_cnt),
        .clr_valid(clr_valid), .clr_mask(clr_mask),
        .shift_data(shift_data), .edge_cnt(edge_cnt),
        .start_flag(start_flag), .ovf_flag(ovf_flag),
        .stop_flag(stop_flag), .coll_flag(coll_flag)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        for (int k = 0; k < 1000 && !scl_line; k++) @(negedge clk);
        check("R3/R7 clock line released", int'(scl_line), 1);
    endtask

    // controller write: one cycle of loads and/or clears
    task automatic ctl(input logic [3:0] cm, input logic lc, input logic [3:0] cv,
                       input logic ld, input logic [7:0] dv);
        clr_valid = |cm; clr_mask = cm;
        ld_cnt_valid = lc; ld_cnt = cv;
        ld_data_valid = ld; ld_data = dv;
        @(negedge clk);
        clr_valid = 1'b0; ld_cnt_valid = 1'b0; ld_data_valid = 1'b0;
        wait_cyc(2);
    endtask

    task automatic clk_bit(input logic b);
        sda_m = b; wait_cyc(HALF);
        scl_m = 1'b1; wait_scl_high();
        wait_cyc(HALF/2); pull_mid = sda_pull_low; wait_cyc(HALF/2);
        scl_m = 1'b0; wait_cyc(HALF);
    endtask

    task automatic t_reset();
        wait_cyc(5); rst_n = 1'b1; wait_cyc(2);
        check("R1 flags", int'({coll_flag, stop_flag, ovf_flag, start_flag}), 0);
        check("R1 pulls", int'({scl_pull_low, sda_pull_low}), 0);
        check("R1 counter", int'(edge_cnt), 0);
        check("R1 data", int'(shift_data), 0);
    endtask

    task automatic t_start();
        sda_m = 1'b0; wait_cyc(HALF);
        check("R2 start flag", int'(start_flag), 1);
        check("R3 no pull while high", int'(scl_pull_low), 0);
        scl_m = 1'b0; wait_cyc(HALF);
        check("R3 stretch after start", int'(scl_pull_low), 1);
        wait_cyc(20);
        check("R3 still held", int'(scl_pull_low), 1);
        ctl(4'b0001, 1'b1, 4'd0, 1'b0, 8'h00);
        check("R3 released on clear", int'(scl_pull_low), 0);
        check("R12 counter load", int'(edge_cnt), 0);
    endtask

    task automatic t_rx_hold();
        logic [7:0] v = 8'hA5;
        mode_hold = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(v[i]);
            if (i == 7) check("R4 two edges per bit", int'(edge_cnt), 2);
        end
        check("R4 overflow after 16 edges", int'(ovf_flag), 1);
        check("R4 counter wrapped", int'(edge_cnt), 0);
        check("R5 received byte", int'(shift_data), 'hA5);
        check("R7 hold mode stretch", int'(scl_pull_low), 1);
    endtask

    task automatic t_ack();
        drive_en = 1'b1;
        ctl(4'b0010, 1'b1, 4'd14, 1'b1, 8'h00);
        check("R8 ack drives low", int'(sda_pull_low), 1);
        clk_bit(1'b1);
        check("R8 ack held at high phase", int'(pull_mid), 1);
        check("R6 overflow after two edges", int'(ovf_flag), 1);
        drive_en = 1'b0; wait_cyc(1);
        check("R8 release when not driving", int'(sda_pull_low), 0);
    endtask

    task automatic t_tx();
        logic [7:0] v = 8'h3C;
        drive_en = 1'b1;
        ctl(4'b0010, 1'b1, 4'd0, 1'b1, v);
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1);
            check("R8 msb-first bit", int'(pull_mid), int'(!v[i]));
        end
        check("R4 tx overflow", int'(ovf_flag), 1);
        check("R5 bus echo", int'(shift_data), 'h3C);
        drive_en = 1'b0; wait_cyc(1);
    endtask

    task automatic t_stop();
        ctl(4'b0010, 1'b0, 4'd0, 1'b0, 8'h00);
        sda_m = 1'b0; wait_cyc(HALF);
        scl_m = 1'b1; wait_scl_high(); wait_cyc(HALF);
        sda_m = 1'b1; wait_cyc(HALF);
        check("R9 stop flag", int'(stop_flag), 1);
        check("R9 no stretch on stop", int'(scl_pull_low), 0);
        check("R9 no start on stop", int'(start_flag), 0);
    endtask

    task automatic t_plain();
        logic [7:0] v = 8'h5A;
        mode_hold = 1'b0;
        sda_m = 1'b0; wait_cyc(HALF);
        scl_m = 1'b0; wait_cyc(HALF);
        ctl(4'b0101, 1'b1, 4'd0, 1'b0, 8'h00);
        check("R10 start and stop cleared", int'({stop_flag, start_flag}), 0);
        for (int i = 7; i >= 0; i--) clk_bit(v[i]);
        check("R7 plain overflow", int'(ovf_flag), 1);
        check("R7 plain no stretch", int'(scl_pull_low), 0);
        check("R5 plain byte", int'(shift_data), 'h5A);
    endtask

    task automatic t_clear_mask();
        sda_m = 1'b1; wait_cyc(HALF);
        scl_m = 1'b1; wait_scl_high(); wait_cyc(HALF);
        sda_m = 1'b0; wait_cyc(HALF);
        check("R2 repeated start", int'(start_flag), 1);
        ctl(4'b0010, 1'b0, 4'd0, 1'b0, 8'h00);
        check("R10 overflow cleared", int'(ovf_flag), 0);
        check("R10 start kept", int'(start_flag), 1);
        scl_m = 1'b0; wait_cyc(HALF);
        check("R3 stretch after repeated start", int'(scl_pull_low), 1);
        ctl(4'b0001, 1'b1, 4'd5, 1'b1, 8'h81);
        check("R12 counter preload", int'(edge_cnt), 5);
        check("R12 data load", int'(shift_data), 'h81);
    endtask

    task automatic t_coll();
        check("R11 no collision yet", int'(coll_flag), 0);
        drive_en = 1'b1;
        ctl(4'b0000, 1'b1, 4'd0, 1'b1, 8'hFF);
        clk_bit(1'b0);
        check("R11 collision flag", int'(coll_flag), 1);
        drive_en = 1'b0;
        ctl(4'b1000, 1'b0, 4'd0, 1'b0, 8'h00);
        check("R10 collision cleared", int'(coll_flag), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_start();
        t_rx_hold();
        t_ack();
        t_tx();
        t_stop();
        t_plain();
        t_clear_mask();
        t_coll();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule